// File: doc/BRIEF.md
# Ternary Successive-Approximation Conversion Controller

This block sequences a two-comparator successive-approximation conversion that resolves one balanced-ternary digit (+1, 0 or -1) in every comparison cycle. Two capacitor DAC arrays sit in front of two comparators. In each cycle the controller drives every capacitor of both arrays to one of three levels: reference, common mode or ground. This sets the two comparator thresholds one third of the remaining range above and below the current estimate. The two decisions then pick one of three sub-ranges.

A one-cycle sample strobe starts a conversion. The controller first releases the top-plate common-mode switches, the second array before the first. It then runs `NDIG` comparison cycles, starting at the most significant capacitor. At the end it presents the digit word, a signed two's-complement equivalent, an error flag for an impossible comparator pair, and a one-clock done pulse. The analog arrays and comparators live outside this block.

Top module: `tsar_ctrl`

## Requirements
- R1: After reset, and whenever idle, both common-mode outputs are 1, every switch code is 00, and done and busy are 0.
- R2: The clock edge that samples a strobe in idle starts a conversion. In the next cycle `cm_b_o` is 0 while `cm_a_o` stays 1. From the cycle after that, both are 0 until the conversion ends.
- R3: A conversion takes exactly `NDIG` comparison cycles. `done_o` is 1 for exactly one clock, in the (`NDIG`+2)th cycle after the strobe-sampling edge, and busy is 1 from the strobe until then.
- R4: A comparator pair (hi, lo) decodes as (1,1) to +1, (0,1) to 0 and (0,0) to -1. Switch codes and digit fields use 01 for +1 (reference), 00 for 0 (common mode) and 11 for -1 (ground). Code 10 never appears.
- R5: The pair (1,0) is impossible. It yields digit 0, and `err_o` is 1 from the done cycle until the next accepted strobe.
- R6: In the first comparison cycle, capacitor `NDIG`-1 is 00 in both arrays, all lower capacitors are 01 in array A, and all lower capacitors are 11 in array B.
- R7: In comparison cycle k (capacitor p = `NDIG`-1-k), capacitors above p carry their decided digit code in both arrays. Capacitor p is 00, and the capacitors below p are 01 in array A and 11 in array B.
- R8: Digit i of the result sits in `digits_o[2i+1:2i]`, and digit `NDIG`-1 is resolved first.
- R9: `bin_o` equals the sum of D_i times 3^i, within plus or minus (3^`NDIG`-1)/2.
- R10: A strobe while busy has no effect on timing or result.
- R11: The digit word, `bin_o` and `err_o` hold their values after done until the next accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Conversion start strobe |
| cmp_hi_i | input | 1 | Upper-threshold comparator decision |
| cmp_lo_i | input | 1 | Lower-threshold comparator decision |
| cm_a_o | output | 1 | Array A top-plate common-mode switch closed |
| cm_b_o | output | 1 | Array B top-plate common-mode switch closed |
| sw_a_o | output | 2*NDIG | Array A capacitor switch codes |
| sw_b_o | output | 2*NDIG | Array B capacitor switch codes |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-clock completion pulse |
| digits_o | output | 2*NDIG | Ternary digit word |
| bin_o | output | BW | Signed two's-complement result |
| err_o | output | 1 | Impossible comparator pair seen |

## Verification
The hardest conditions to reach from the ports are the late-cycle switch patterns. In those cycles, decided capacitors mix with the current and lower ones, and the patterns depend on every earlier decision. The bench closes the loop with an integer model of both arrays that turns the switch codes into comparator decisions. It sweeps every input level of a four-digit configuration, from -40 to +40. For each level it checks each cycle's code pattern against the balanced-ternary expansion computed in the bench. Forced comparator patterns reach the impossible pair and the saturated extremes, and a strobe inserted mid-conversion exercises the ignore rule.

// File: rtl/tsar_pkg.sv
package tsar_pkg;
  typedef logic [1:0] tcode_t;
  localparam tcode_t TC_POS = 2'b01;
  localparam tcode_t TC_MID = 2'b00;
  localparam tcode_t TC_NEG = 2'b11;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SPLIT = 2'd1,
    S_CONV  = 2'd2,
    S_DONE  = 2'd3
  } tsar_state_e;
endpackage

// File: rtl/tsar_digit_decode.sv
module tsar_digit_decode
  import tsar_pkg::*;
(
  input  logic   hi_i,
  input  logic   lo_i,
  output tcode_t dig_o,
  output logic   bad_o
);
  always_comb begin
    bad_o = 1'b0;
    unique case ({hi_i, lo_i})
      2'b11:   dig_o = TC_POS;
      2'b01:   dig_o = TC_MID;
      2'b00:   dig_o = TC_NEG;
      default: begin
        dig_o = TC_MID;
        bad_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/tsar_switch_map.sv
module tsar_switch_map
  import tsar_pkg::*;
#(
  parameter int NDIG = 4,
  parameter int IW   = 2
) (
  input  logic              active_i,
  input  logic [IW-1:0]     pos_i,
  input  logic [2*NDIG-1:0] decided_i,
  output logic [2*NDIG-1:0] sw_a_o,
  output logic [2*NDIG-1:0] sw_b_o
);
  for (genvar g = 0; g < NDIG; g++) begin : g_cap
    always_comb begin
      if (!active_i) begin
        sw_a_o[2*g +: 2] = TC_MID;
        sw_b_o[2*g +: 2] = TC_MID;
      end else if (g > int'(pos_i)) begin
        sw_a_o[2*g +: 2] = decided_i[2*g +: 2];
        sw_b_o[2*g +: 2] = decided_i[2*g +: 2];
      end else if (g == int'(pos_i)) begin
        sw_a_o[2*g +: 2] = TC_MID;
        sw_b_o[2*g +: 2] = TC_MID;
      end else begin
        sw_a_o[2*g +: 2] = TC_POS;
        sw_b_o[2*g +: 2] = TC_NEG;
      end
    end
  end
endmodule

// File: rtl/tsar_accum.sv
module tsar_accum
  import tsar_pkg::*;
#(
  parameter int BW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 step_i,
  input  tcode_t               dig_i,
  output logic signed [BW-1:0] acc_o
);
  logic signed [BW-1:0] acc_q, acc_n, dig_ext;

  assign dig_ext = $signed({{(BW-2){dig_i[1]}}, dig_i});

  always_comb begin
    acc_n = acc_q;
    if (clr_i)       acc_n = '0;
    else if (step_i) acc_n = (acc_q <<< 1) + acc_q + dig_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                acc_q <= '0;
    else if (clr_i || step_i)  acc_q <= acc_n;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/tsar_ctrl.sv
module tsar_ctrl
  import tsar_pkg::*;
#(
  parameter  int NDIG   = 4,
  localparam int MAXMAG = (3**NDIG - 1) / 2,
  localparam int BW     = $clog2(MAXMAG + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic                 cmp_hi_i,
  input  logic                 cmp_lo_i,
  output logic                 cm_a_o,
  output logic                 cm_b_o,
  output logic [2*NDIG-1:0]    sw_a_o,
  output logic [2*NDIG-1:0]    sw_b_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [2*NDIG-1:0]    digits_o,
  output logic signed [BW-1:0] bin_o,
  output logic                 err_o
);
  localparam int IW = (NDIG > 1) ? $clog2(NDIG) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  tsar_state_e       state_q, state_n;
  logic [IW-1:0]     pos_q, pos_n;
  logic [2*NDIG-1:0] dig_q, dig_n;
  logic              err_q, err_n;
  logic              start, step;
  tcode_t            dec_dig;
  logic              dec_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  tsar_digit_decode u_dec (
    .hi_i  (cmp_hi_i),
    .lo_i  (cmp_lo_i),
    .dig_o (dec_dig),
    .bad_o (dec_bad)
  );

  assign start = (state_q == S_IDLE) && sample_i;
  assign step  = (state_q == S_CONV);

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    dig_n   = dig_q;
    err_n   = err_q;
    unique case (state_q)
      S_IDLE: if (sample_i) begin
        state_n = S_SPLIT;
        dig_n   = '0;
        err_n   = 1'b0;
      end
      S_SPLIT: begin
        state_n = S_CONV;
        pos_n   = IW'(NDIG - 1);
      end
      S_CONV: begin
        dig_n[2*int'(pos_q) +: 2] = dec_dig;
        err_n = err_q | dec_bad;
        if (pos_q == '0) state_n = S_DONE;
        else             pos_n   = pos_q - IW'(1);
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_IDLE;
      pos_q   <= '0;
      dig_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      if (state_q == S_SPLIT || step) pos_q <= pos_n;
      if (start || step) begin
        dig_q <= dig_n;
        err_q <= err_n;
      end
    end
  end

  tsar_switch_map #(.NDIG(NDIG), .IW(IW)) u_map (
    .active_i  (step),
    .pos_i     (pos_q),
    .decided_i (dig_q),
    .sw_a_o    (sw_a_o),
    .sw_b_o    (sw_b_o)
  );

  tsar_accum #(.BW(BW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_s),
    .clr_i  (start),
    .step_i (step),
    .dig_i  (dec_dig),
    .acc_o  (bin_o)
  );

  assign cm_a_o   = (state_q == S_IDLE) || (state_q == S_SPLIT);
  assign cm_b_o   = (state_q == S_IDLE);
  assign busy_o   = (state_q != S_IDLE);
  assign done_o   = (state_q == S_DONE);
  assign digits_o = dig_q;
  assign err_o    = err_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |=> !done_o);

  // R2
  cm_order_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(cm_a_o) |-> $past(!cm_b_o));

  // R3
  pos_walk_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (step && pos_q != '0) |=> (step && pos_q == $past(pos_q) - IW'(1)));

  // R9
  bin_range_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done_o |-> (int'(bin_o) <= MAXMAG && int'(bin_o) >= -MAXMAG));

  for (genvar c = 0; c < NDIG; c++) begin : g_code_chk
    // R4
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_s)
      (sw_a_o[2*c +: 2] != 2'b10) && (sw_b_o[2*c +: 2] != 2'b10)
      && (digits_o[2*c +: 2] != 2'b10));
  end
endmodule

// File: tb/tb_tsar_ctrl.sv
module tb_tsar_ctrl;
  localparam int NDIG   = 4;
  localparam int MAXMAG = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic cmp_hi, cmp_lo;
  logic cm_a, cm_b, busy, done, err;
  logic [2*NDIG-1:0] sw_a, sw_b, digits;
  logic signed [6:0] bin;

  int x = 0;
  int mode = 0;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int ed [NDIG];

  always #4 clk = ~clk;

  tsar_ctrl #(.NDIG(NDIG)) dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample),
    .cmp_hi_i(cmp_hi), .cmp_lo_i(cmp_lo),
    .cm_a_o(cm_a), .cm_b_o(cm_b), .sw_a_o(sw_a), .sw_b_o(sw_b),
    .busy_o(busy), .done_o(done), .digits_o(digits), .bin_o(bin), .err_o(err)
  );

  function automatic int cval(input logic [1:0] c);
    if (c == 2'b01) return 1;
    if (c == 2'b11) return -1;
    return 0;
  endfunction

  function automatic logic [1:0] enc(input int d);
    if (d > 0) return 2'b01;
    if (d < 0) return 2'b11;
    return 2'b00;
  endfunction

  function automatic int dac(input logic [2*NDIG-1:0] v);
    int s = 0;
    for (int i = 0; i < NDIG; i++) s += cval(v[2*i +: 2]) * (3**i);
    return s;
  endfunction

  // integer model of both arrays and comparators
  always_comb begin
    unique case (mode)
      1: begin cmp_hi = 1'b1; cmp_lo = 1'b1; end
      2: begin cmp_hi = 1'b0; cmp_lo = 1'b0; end
      3: begin cmp_hi = 1'b1; cmp_lo = 1'b0; end
      default: begin
        cmp_hi = (x > dac(sw_a));
        cmp_lo = (x >= dac(sw_b));
      end
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s x=%0d mode=%0d actual=%0d expected=%0d", req, x, mode, act, exp);
    end
  endtask

  task automatic expect_digits();
    int v = x;
    for (int i = 0; i < NDIG; i++) begin
      if (mode == 1) ed[i] = 1;
      else if (mode == 2) ed[i] = -1;
      else if (mode == 3) ed[i] = 0;
      else begin
        int r = ((v % 3) + 3) % 3;
        if (r == 2) begin ed[i] = -1; v = (v + 1) / 3; end
        else begin ed[i] = r; v = (v - r) / 3; end
      end
    end
  endtask

  task automatic run_conv(input bit poke_busy);
    logic [2*NDIG-1:0] ea, eb, ew;
    int eb_val;
    expect_digits();
    ew = '0;
    eb_val = 0;
    for (int i = 0; i < NDIG; i++) begin
      ew[2*i +: 2] = enc(ed[i]);
      eb_val += ed[i] * (3**i);
    end
    @(negedge clk); sample = 1'b1;
    @(posedge clk); @(negedge clk); sample = 1'b0;
    chk(cm_a == 1'b1 && cm_b == 1'b0 && busy, "R2 split", {cm_a, cm_b}, 2);
    for (int k = 0; k < NDIG; k++) begin
      int p = NDIG - 1 - k;
      @(posedge clk); @(negedge clk);
      ea = '0; eb = '0;
      for (int i = 0; i < NDIG; i++) begin
        if (i > p) begin ea[2*i +: 2] = enc(ed[i]); eb[2*i +: 2] = enc(ed[i]); end
        else if (i < p) begin ea[2*i +: 2] = 2'b01; eb[2*i +: 2] = 2'b11; end
      end
      if (k == 0) chk(sw_a == ea && sw_b == eb, "R6 first codes", {sw_a, sw_b}, {ea, eb});
      else        chk(sw_a == ea && sw_b == eb, "R7 cycle codes", {sw_a, sw_b}, {ea, eb});
      chk(!cm_a && !cm_b && !done && busy, "R3 compare cycle", {cm_a, cm_b, done, busy}, 1);
      if (poke_busy && k == 1) sample = 1'b1;
      if (poke_busy && k == 2) sample = 1'b0;
    end
    @(posedge clk); @(negedge clk);
    chk(done == 1'b1, "R3 done timing", done, 1);
    chk(digits == ew, "R8 digit word", digits, ew);
    chk(int'(bin) == eb_val, "R9 binary value", int'(bin), eb_val);
    if (mode == 0) chk(int'(bin) == x, "R9 equals input", int'(bin), x);
    chk(err == (mode == 3), "R5 error flag", err, mode == 3);
    @(posedge clk); @(negedge clk);
    chk(!done && !busy && cm_a && cm_b && sw_a == '0 && sw_b == '0, "R1 back to idle",
        {done, busy, cm_a, cm_b}, 3);
    @(posedge clk); @(negedge clk);
    chk(digits == ew && int'(bin) == eb_val && err == (mode == 3), "R11 hold",
        int'(bin), eb_val);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(cm_a && cm_b && !busy && !done && sw_a == '0 && sw_b == '0
        && digits == '0 && bin == '0 && !err, "R1 reset state", {cm_a, cm_b, busy, done}, 12);
    // R4 R8 R9: full sweep through the array model
    mode = 0;
    for (int v = -MAXMAG; v <= MAXMAG; v++) begin
      x = v;
      run_conv(1'b0);
    end
    // R10: strobe during conversion ignored
    x = 17;  run_conv(1'b1);
    x = -29; run_conv(1'b1);
    // R4 saturated extremes
    mode = 1; run_conv(1'b0);
    mode = 2; run_conv(1'b0);
    // R5 impossible comparator pair
    mode = 3; run_conv(1'b0);
    // R5 error clears on next accepted strobe
    mode = 0; x = 5; run_conv(1'b0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule